// File: doc/BRIEF.md
# Vault Sector Buffer Front End

This block sits in front of one DRAM vault and serves one request at a time from two kinds of agent. The external host always moves a whole 128-byte line. Internal lanes move an 8-, 16- or 32-byte piece of one 32-byte sector. The block keeps a fully associative buffer of recently fetched sectors so that repeated lane reads avoid DRAM. Every lane write is also written through to DRAM.

Each 128-byte line carries one ownership bit that applies to all four of its sectors. The bit is either internal (lanes own the line) or external (the host may hold cached copies). A host access always leaves its line external and drops any buffered sectors of that line. A lane that touches an external line first raises a flush request toward the host, carrying the line index. It waits in a single-entry holding register for the acknowledge, flips the line to internal, and then completes. Only internal sectors are ever buffered.

The controller is one state machine with these states:
- `ST_IDLE`: accepts a request.
- `ST_DECIDE`: looks up ownership and the buffer.
- `ST_FLUSH`: waits for the host acknowledge.
- `ST_FILL`: waits for DRAM read data for a lane miss.
- `ST_HOST_ISSUE` and `ST_HOST_WAIT`: step through the four sectors of a host line.
- `ST_RESP`: returns the response.

The transitions are:
- IDLE to DECIDE on a request.
- DECIDE to HOST_ISSUE for a host request.
- DECIDE to FLUSH for a lane request to an external line.
- DECIDE to RESP for a lane write or a lane read hit.
- DECIDE to FILL for a lane read miss.
- FLUSH back to DECIDE on acknowledge.
- FILL to RESP on DRAM data.
- HOST_ISSUE to HOST_WAIT for a host read beat.
- HOST_ISSUE stays in HOST_ISSUE between host write beats.
- HOST_WAIT back to HOST_ISSUE on DRAM data.
- HOST_ISSUE or HOST_WAIT to RESP after the fourth beat.
- RESP to IDLE.

Top module: `vsb_front`

## Requirements
- R1: After reset the block is idle with `req_ready` high, `rsp_valid`, `flush_req` and `dram_req_valid` low. The buffer is empty and every line is internal, so a first lane access raises no flush.
- R2: Lane size code `req_size` is 0 for 8 bytes, 1 for 16 bytes and 2 for 32 bytes, naturally aligned within the sector given by `req_addr[ADDR_W-1:5]`. A lane read returns the requested bytes in the low bits of `rsp_rdata`, with all other bits zero. A lane read miss issues exactly one 32-byte DRAM sector read and keeps the whole sector in the buffer.
- R3: A lane read that hits the buffer issues no DRAM request. Its `rsp_valid` is high one clock edge after the accepting edge.
- R4: A lane write always issues one DRAM write whose `dram_req_be` bit b enables sector byte b, covering exactly the requested bytes. A write that hits also updates the buffered sector, so a later read hit returns the new bytes. A lane write responds one edge after acceptance.
- R5: A host request covers the 128-byte line `req_addr[ADDR_W-1:7]`. It issues four full-sector DRAM operations in sector order 0 to 3. Sector k of the line travels in bits `[256k+255:256k]` of `req_wdata` and `rsp_rdata`. It never raises a flush and leaves the line external.
- R6: A host access invalidates every buffered sector of its line, so the next lane read of such a sector fetches from DRAM.
- R7: A lane access to an external line holds `flush_req` high with `flush_line` stable until `flush_ack`, issuing no DRAM request meanwhile. It then completes normally.
- R8: Ownership is per line. Once a lane access has returned a line to internal, lane accesses to any of its four sectors raise no flush until the host touches it again.
- R9: A fill takes the lowest-index empty entry. When the buffer is full, the victim is chosen by a pointer that starts at entry 0 after reset and advances by one, wrapping, on each eviction.
- R10: One request is in service at a time. `req_ready` drops after acceptance, and each request produces exactly one single-cycle `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_host | input | 1 | 1 = host line request, 0 = lane request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Lane size code (0: 8 B, 1: 16 B, 2: 32 B) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 1024 | Write data: full line for host, low bytes for lane |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 1024 | Read data (zero for writes) |
| dram_req_valid | output | 1 | DRAM sector access, accepted in the same cycle |
| dram_req_write | output | 1 | DRAM access is a write |
| dram_req_sect | output | ADDR_W-5 | DRAM sector address |
| dram_req_be | output | 32 | Byte enables for DRAM writes |
| dram_req_wdata | output | 256 | DRAM write data, byte-aligned within sector |
| dram_rsp_valid | input | 1 | DRAM read data valid |
| dram_rsp_rdata | input | 256 | DRAM read data |
| flush_req | output | 1 | Ask host to flush or invalidate a line |
| flush_line | output | ADDR_W-7 | Line index of the flush |
| flush_ack | input | 1 | Host has flushed the line |

## Verification
All timing is counted from the falling edge at which the bench presents a request. Read hits and lane writes must raise `rsp_valid` two rising edges later, one for acceptance and one for the decision. The scoreboard stores that latency with the expected data and compares it against a cycle counter. Misses, host lines and flushes depend on the bench's own DRAM and host responders, so for those the monitor waits for the response event. It then checks the data, while the DRAM read and write counts, the last write enables and the flush counter are compared before and after each request. Every output is sampled on the falling edge, half a cycle clear of the edge that changes it.

// File: rtl/vsb_pkg.sv
`timescale 1ns/1ps
package vsb_pkg;
    localparam int SECT_BYTES = 32;
    localparam int SECT_W     = SECT_BYTES * 8;
    localparam int LINE_SECTS = 4;
    localparam int LINE_W     = SECT_W * LINE_SECTS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FLUSH,
        ST_FILL,
        ST_HOST_ISSUE,
        ST_HOST_WAIT,
        ST_RESP
    } vsb_state_e;

    // byte-enable pattern of a lane access inside its sector
    function automatic logic [SECT_BYTES-1:0] lane_be(input logic [1:0] sz, input logic [4:0] off);
        logic [SECT_BYTES-1:0] m;
        unique case (sz)
            2'd0:    m = SECT_BYTES'(32'h0000_00FF);
            2'd1:    m = SECT_BYTES'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m << off;
    endfunction
endpackage

// File: rtl/vsb_owner.sv
`timescale 1ns/1ps
module vsb_owner #(
    parameter int LAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LAW-1:0] line,
    output logic           ext,
    input  logic           set_ext,
    input  logic           set_int
);
    localparam int LINES = 1 << LAW;

    logic [LINES-1:0] own_ext;

    assign ext = own_ext[line];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_ext <= '0;
        end else if (set_ext) begin
            own_ext[line] <= 1'b1;
        end else if (set_int) begin
            own_ext[line] <= 1'b0;
        end
    end
endmodule

// File: rtl/vsb_store.sv
`timescale 1ns/1ps
module vsb_store #(
    parameter int ENTRIES = 256,
    parameter int SAW     = 11,
    parameter int SECT_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAW-1:0]    lk_sect,
    output logic              hit,
    output logic [SECT_W-1:0] hit_data,
    input  logic              fill_en,
    input  logic [SECT_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [SECT_W/8-1:0] upd_be,
    input  logic [SECT_W-1:0] upd_data,
    input  logic              inv_en
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int BE_W  = SECT_W / 8;

    logic [ENTRIES-1:0] valid;
    logic [SAW-1:0]     tag  [ENTRIES];
    logic [SECT_W-1:0]  data [ENTRIES];
    logic [IDX_W-1:0]   rr, hit_idx, free_idx, victim;
    logic               any_free;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid[i] && tag[i] == lk_sect && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim   = any_free ? free_idx : rr;
    assign hit_data = data[hit_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
            rr    <= '0;
        end else begin
            if (inv_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (tag[i][SAW-1:2] == lk_sect[SAW-1:2]) valid[i] <= 1'b0;
                end
            end
            if (fill_en) begin
                valid[victim] <= 1'b1;
                if (!any_free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag[victim]  <= lk_sect;
            data[victim] <= fill_data;
        end
        if (upd_en && hit) begin
            for (int b = 0; b < BE_W; b++) begin
                if (upd_be[b]) data[hit_idx][b*8 +: 8] <= upd_data[b*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/vsb_front.sv
`timescale 1ns/1ps
module vsb_front
    import vsb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_host,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1023:0]       req_wdata,
    output logic                rsp_valid,
    output logic [1023:0]       rsp_rdata,
    output logic                dram_req_valid,
    output logic                dram_req_write,
    output logic [ADDR_W-6:0]   dram_req_sect,
    output logic [31:0]         dram_req_be,
    output logic [255:0]        dram_req_wdata,
    input  logic                dram_rsp_valid,
    input  logic [255:0]        dram_rsp_rdata,
    output logic                flush_req,
    output logic [ADDR_W-8:0]   flush_line,
    input  logic                flush_ack
);
    localparam int SAW = ADDR_W - 5;
    localparam int LAW = ADDR_W - 7;

    vsb_state_e state, state_nx;

    // single-entry holding register for the request in service
    logic              h_host, h_write;
    logic [1:0]        h_size;
    logic [ADDR_W-1:0] h_addr;
    logic [LINE_W-1:0] h_wdata;
    logic [1:0]        beat;
    logic [LINE_W-1:0] rdata_q;

    logic [SAW-1:0]    h_sect;
    logic [LAW-1:0]    h_line;
    logic [4:0]        h_off;
    logic [SECT_BYTES-1:0] h_be;
    logic [SECT_W-1:0] lane_wsec;
    logic              line_ext, buf_hit;
    logic [SECT_W-1:0] buf_data;
    logic              own_set_ext, own_set_int;
    logic              fill_en, upd_en;
    logic              lane_ok;

    assign h_sect    = h_addr[ADDR_W-1:5];
    assign h_line    = h_addr[ADDR_W-1:7];
    assign h_off     = h_addr[4:0];
    assign h_be      = lane_be(h_size, h_off);
    assign lane_wsec = h_wdata[SECT_W-1:0] << {h_off, 3'b000};
    assign lane_ok   = !h_host && !line_ext;

    function automatic logic [LINE_W-1:0] pick(input logic [SECT_W-1:0] sec,
                                               input logic [1:0] sz, input logic [4:0] off);
        logic [SECT_W-1:0] v;
        v = sec >> {off, 3'b000};
        unique case (sz)
            2'd0:    v = v & SECT_W'({64{1'b1}});
            2'd1:    v = v & SECT_W'({128{1'b1}});
            default: v = v;
        endcase
        return LINE_W'(v);
    endfunction

    vsb_owner #(.LAW(LAW)) u_owner (
        .clk(clk), .rst_n(rst_n), .line(h_line), .ext(line_ext),
        .set_ext(own_set_ext), .set_int(own_set_int)
    );

    vsb_store #(.ENTRIES(ENTRIES), .SAW(SAW), .SECT_W(SECT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .lk_sect(h_sect), .hit(buf_hit), .hit_data(buf_data),
        .fill_en(fill_en), .fill_data(dram_rsp_rdata),
        .upd_en(upd_en), .upd_be(h_be), .upd_data(lane_wsec),
        .inv_en(own_set_ext)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (h_host)                  state_nx = ST_HOST_ISSUE;
                else if (line_ext)           state_nx = ST_FLUSH;
                else if (h_write || buf_hit) state_nx = ST_RESP;
                else                         state_nx = ST_FILL;
            end
            ST_FLUSH:      if (flush_ack) state_nx = ST_DECIDE;
            ST_FILL:       if (dram_rsp_valid) state_nx = ST_RESP;
            ST_HOST_ISSUE: begin
                if (!h_write)          state_nx = ST_HOST_WAIT;
                else if (beat == 2'd3) state_nx = ST_RESP;
            end
            ST_HOST_WAIT:  if (dram_rsp_valid) state_nx = (beat == 2'd3) ? ST_RESP : ST_HOST_ISSUE;
            ST_RESP:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        req_ready      = (state == ST_IDLE);
        rsp_valid      = (state == ST_RESP);
        rsp_rdata      = rdata_q;
        flush_req      = (state == ST_FLUSH);
        flush_line     = h_line;
        dram_req_valid = 1'b0;
        dram_req_write = h_write;
        dram_req_sect  = h_sect;
        dram_req_be    = h_be;
        dram_req_wdata = lane_wsec;
        own_set_ext    = 1'b0;
        own_set_int    = 1'b0;
        fill_en        = 1'b0;
        upd_en         = 1'b0;
        unique case (state)
            ST_DECIDE: begin
                own_set_ext    = h_host;
                dram_req_valid = lane_ok && (h_write || !buf_hit);
                upd_en         = lane_ok && h_write;
            end
            ST_FLUSH:      own_set_int = flush_ack;
            ST_FILL:       fill_en     = dram_rsp_valid;
            ST_HOST_ISSUE: begin
                dram_req_valid = 1'b1;
                dram_req_sect  = {h_line, beat};
                dram_req_be    = '1;
                dram_req_wdata = h_wdata[int'(beat)*SECT_W +: SECT_W];
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_host  <= 1'b0;
            h_write <= 1'b0;
            h_size  <= '0;
            h_addr  <= '0;
            h_wdata <= '0;
            beat    <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    h_host  <= req_host;
                    h_write <= req_write;
                    h_size  <= req_size;
                    h_addr  <= req_addr;
                    h_wdata <= req_wdata;
                    beat    <= '0;
                    rdata_q <= '0;
                end
                ST_DECIDE: if (lane_ok && !h_write && buf_hit) rdata_q <= pick(buf_data, h_size, h_off);
                ST_FILL:   if (dram_rsp_valid) rdata_q <= pick(dram_rsp_rdata, h_size, h_off);
                ST_HOST_ISSUE: if (h_write) beat <= beat + 1'b1;
                ST_HOST_WAIT: if (dram_rsp_valid) begin
                    rdata_q[int'(beat)*SECT_W +: SECT_W] <= dram_rsp_rdata;
                    beat <= beat + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vsb_front_chk.sv
`timescale 1ns/1ps
module vsb_front_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              dram_req_valid,
    input logic              dram_req_write,
    input logic [31:0]       dram_req_be,
    input logic              flush_req,
    input logic [ADDR_W-8:0] flush_line,
    input logic              flush_ack
);
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    a_r10_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r10_rsp_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r7_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req && $stable(flush_line));

    a_r7_no_dram_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !dram_req_valid);

    a_r4_write_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        dram_req_valid && dram_req_write |-> dram_req_be != '0);
endmodule

bind vsb_front vsb_front_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vsb_front_tb.sv
`timescale 1ns/1ps
module vsb_front_tb;
    localparam int AW = 16;
    localparam int NE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_host = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1023:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [1023:0] rsp_rdata;
    logic dram_req_valid, dram_req_write;
    logic [AW-6:0] dram_req_sect;
    logic [31:0] dram_req_be;
    logic [255:0] dram_req_wdata;
    logic dram_rsp_valid = 1'b0;
    logic [255:0] dram_rsp_rdata = '0;
    logic flush_req;
    logic [AW-8:0] flush_line;
    logic flush_ack = 1'b0;

    always #2.5 clk = ~clk;

    vsb_front #(.ADDR_W(AW), .ENTRIES(NE)) u_dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    int dram_rd = 0, dram_wr = 0, flush_cnt = 0, flush_ln = -1, rd_at_flush = 0;
    int last_wsect = -1;
    logic [31:0] last_be = '0;
    logic [255:0] dmem [int];
    logic [255:0] refm [int];

    typedef struct { logic [1023:0] d; string rq; int lat; int t0; } exp_t;
    exp_t exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [255:0] init_pat(int s);
        logic [255:0] p;
        for (int b = 0; b < 32; b++) p[b*8 +: 8] = 8'(s * 7 + b * 13 + 1);
        return p;
    endfunction
    function automatic logic [255:0] dm_rd(int s);
        return dmem.exists(s) ? dmem[s] : init_pat(s);
    endfunction
    function automatic logic [255:0] ref_rd(int s);
        return refm.exists(s) ? refm[s] : init_pat(s);
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp_v);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // DRAM responder: posted writes, reads answered after two cycles
    initial begin
        bit again = 0;
        forever begin
            if (!again) @(negedge clk);
            again = 0;
            if (dram_req_valid && rst_n) begin
                if (dram_req_write) begin
                    logic [255:0] v;
                    v = dm_rd(int'(dram_req_sect));
                    for (int b = 0; b < 32; b++)
                        if (dram_req_be[b]) v[b*8 +: 8] = dram_req_wdata[b*8 +: 8];
                    dmem[int'(dram_req_sect)] = v;
                    dram_wr++;
                    last_be = dram_req_be;
                    last_wsect = int'(dram_req_sect);
                end else begin
                    int s;
                    s = int'(dram_req_sect);
                    dram_rd++;
                    repeat (2) @(negedge clk);
                    dram_rsp_valid = 1'b1;
                    dram_rsp_rdata = dm_rd(s);
                    @(negedge clk);
                    dram_rsp_valid = 1'b0;
                    again = 1;
                end
            end
        end
    end

    // host flush responder
    initial begin
        forever begin
            @(negedge clk);
            if (flush_req && !flush_ack) begin
                flush_cnt++;
                flush_ln = int'(flush_line);
                rd_at_flush = dram_rd;
                repeat (3) @(negedge clk);
                flush_ack = 1'b1;
                @(negedge clk);
                flush_ack = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected response actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rsp_rdata !== e.d) begin
                        errors++;
                        $display("FAIL %s data actual=%h expected=%h", e.rq, rsp_rdata, e.d);
                    end
                    if (e.lat > 0) chk(cyc - e.t0 == e.lat, {e.rq, " latency"}, cyc - e.t0, e.lat);
                end
            end
        end
    end

    task automatic send(input bit host, input bit wr, input logic [1:0] sz, input int sect,
                        input int off, input logic [1023:0] wd, input string rq, input int lat);
        exp_t e;
        int nb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_host = host; req_write = wr; req_size = sz;
        req_addr = AW'(sect * 32 + off); req_wdata = wd;
        e.d = '0; e.rq = rq; e.lat = lat; e.t0 = cyc;
        nb = 8 << sz;
        if (host) begin
            for (int k = 0; k < 4; k++) begin
                if (wr) refm[sect + k] = wd[k*256 +: 256];
                else    e.d[k*256 +: 256] = ref_rd(sect + k);
            end
        end else begin
            logic [255:0] v;
            v = ref_rd(sect);
            for (int b = 0; b < nb; b++) begin
                if (wr) v[(off + b)*8 +: 8] = wd[b*8 +: 8];
                else    e.d[b*8 +: 8] = v[(off + b)*8 +: 8];
            end
            if (wr) refm[sect] = v;
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 busy after accept", req_ready, 0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        int r0, w0, f0;
        logic [1023:0] hl;
        do_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        chk(flush_req == 1'b0, "R1 flush", flush_req, 0);
        chk(dram_req_valid == 1'b0, "R1 dram", dram_req_valid, 0);

        // R2 lane read miss, 8 bytes
        r0 = dram_rd;
        send(0, 0, 2'd0, 8, 8, '0, "R2 read 8B miss", 0);
        chk(dram_rd == r0 + 1, "R2 one sector read", dram_rd, r0 + 1);
        chk(flush_cnt == 0, "R1 no flush after reset", flush_cnt, 0);

        // R3 hits of the kept sector
        r0 = dram_rd;
        send(0, 0, 2'd1, 8, 16, '0, "R3 read 16B hit", 2);
        send(0, 0, 2'd2, 8, 0, '0, "R3 read 32B hit", 2);
        chk(dram_rd == r0, "R3 no DRAM on hit", dram_rd, r0);

        // R4 write hit then read hit
        w0 = dram_wr; r0 = dram_rd;
        send(0, 1, 2'd0, 8, 0, 1024'h1122_3344_5566_7788, "R4 write 8B hit", 2);
        chk(dram_wr == w0 + 1, "R4 write through", dram_wr, w0 + 1);
        chk(last_be == 32'h0000_00FF, "R4 byte enables", last_be, 32'hFF);
        send(0, 0, 2'd2, 8, 0, '0, "R4 read after write hit", 2);
        chk(dram_rd == r0, "R4 buffer updated", dram_rd, r0);

        // R4 write miss at offset 16
        w0 = dram_wr;
        send(0, 1, 2'd1, 20, 16, {896'b0, 128'hDEAD_BEEF_0BAD_F00D_CAFE_1234_5678_9ABC}, "R4 write 16B miss", 2);
        chk(last_be == 32'hFFFF_0000, "R4 byte enables offset", last_be, 32'hFFFF0000);
        send(0, 0, 2'd1, 20, 16, '0, "R2 read 16B after write", 0);

        // R5 host read line 2
        r0 = dram_rd; f0 = flush_cnt;
        send(1, 0, 2'd0, 8, 0, '0, "R5 host read line", 0);
        chk(dram_rd == r0 + 4, "R5 four sector reads", dram_rd, r0 + 4);
        chk(flush_cnt == f0, "R5 host never flushes", flush_cnt, f0);

        // R7 lane touches external line
        r0 = dram_rd;
        send(0, 0, 2'd0, 9, 24, '0, "R7 read after host", 0);
        chk(flush_cnt == f0 + 1, "R7 flush raised", flush_cnt, f0 + 1);
        chk(flush_ln == 2, "R7 flush line", flush_ln, 2);
        chk(rd_at_flush == r0, "R7 no DRAM before ack", rd_at_flush, r0);
        // R6 sector 8 was dropped; R8 no flush for sibling sector
        r0 = dram_rd;
        send(0, 0, 2'd2, 8, 0, '0, "R6 read invalidated sector", 0);
        chk(dram_rd == r0 + 1, "R6 refetch after host", dram_rd, r0 + 1);
        chk(flush_cnt == f0 + 1, "R8 no second flush", flush_cnt, f0 + 1);

        // R5 host write line 5, then lane write and reads
        for (int k = 0; k < 32; k++) hl[k*32 +: 32] = 32'hC0DE_0000 + k;
        w0 = dram_wr;
        send(1, 1, 2'd0, 20, 0, hl, "R5 host write line", 0);
        chk(dram_wr == w0 + 4, "R5 four sector writes", dram_wr, w0 + 4);
        chk(last_wsect == 23, "R5 sector order", last_wsect, 23);
        f0 = flush_cnt; w0 = dram_wr;
        send(0, 1, 2'd0, 21, 8, 1024'hAAAA_BBBB_CCCC_DDDD, "R7 write external line", 2 + 0 * 0 - 2);
        chk(flush_cnt == f0 + 1, "R7 flush on write", flush_cnt, f0 + 1);
        chk(dram_wr == w0 + 1, "R7 write completes", dram_wr, w0 + 1);
        r0 = dram_rd;
        send(0, 0, 2'd2, 20, 0, '0, "R6 host data after invalidate", 0);
        chk(dram_rd == r0 + 1, "R6 miss after host write", dram_rd, r0 + 1);
        send(0, 0, 2'd2, 21, 0, '0, "R8 read merged sector", 0);
        chk(flush_cnt == f0 + 1, "R8 line stays internal", flush_cnt, f0 + 1);

        // R9 replacement with four entries
        do_reset();
        for (int s = 40; s <= 44; s++) send(0, 0, 2'd2, s, 0, '0, "R9 fill", 0);
        r0 = dram_rd;
        send(0, 0, 2'd2, 41, 0, '0, "R9 survivor hit", 2);
        chk(dram_rd == r0, "R9 entry1 kept", dram_rd, r0);
        send(0, 0, 2'd2, 40, 0, '0, "R9 victim refetch", 0);
        chk(dram_rd == r0 + 1, "R9 entry0 evicted first", dram_rd, r0 + 1);
        send(0, 0, 2'd2, 42, 0, '0, "R9 entry2 hit", 2);
        chk(dram_rd == r0 + 1, "R9 entry2 kept", dram_rd, r0 + 1);
        send(0, 0, 2'd2, 41, 0, '0, "R9 second victim", 0);
        chk(dram_rd == r0 + 2, "R9 pointer advanced", dram_rd, r0 + 2);

        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule